// File: doc/BRIEF.md
# Weighted Latency Cycle Accumulator

This block measures how long transactions sit in a bus request queue. It keeps its own count of the transactions in flight. A one-cycle allocate pulse raises that count and a one-cycle deallocate pulse lowers it. On every clock where measurement is switched on, the block adds the current in-flight count to a 64-bit accumulator. The total therefore grows by the number of waiting transactions in each cycle. Divided by the number of completed transactions, it gives the mean queue latency.

Software reaches the block through a plain register port with one write strobe and a combinational read. The port decodes two adjacent addresses. The lower address is a control word whose only live bit is the enable. The next address holds the 64-bit accumulator, which software can read or preload. Clearing the enable freezes the total and does not clear it. The block has no data stream of its own, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `lat_accum_top`

## Requirements
- R1: After reset, the control word and the accumulator both read zero, and the in-flight count is zero.
- R2: The control word sits at address BASE_ADDR (default 8). Its enable is bit 26, which is writable and reads back. All other bits read zero, and writes to them have no effect.
- R3: The accumulator sits at address BASE_ADDR+1 and reads back as a full 64-bit value.
- R4: While the enable is set, each clock adds to the accumulator the in-flight count as it stood before that clock's pulses.
- R5: An allocate pulse alone raises the in-flight count by one, and a deallocate pulse alone lowers it by one. Both pulses in the same cycle leave it unchanged.
- R6: A lone deallocate at an in-flight count of zero is ignored. A lone allocate at the maximum, 2^OCC_W-1 (31 by default), is ignored.
- R7: While the enable is clear, the accumulator holds its value. The in-flight count keeps tracking the pulses.
- R8: A write to the accumulator address loads the written value. In that cycle the load replaces any accumulation.
- R9: The accumulator wraps modulo 2^64.
- R10: Any address other than the two decoded ones reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | One transaction entered the queue |
| dealloc_i | input | 1 | One transaction left the queue |
| reg_addr_i | input | ADDR_W | Register address, used for both read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i (combinational) |

## Verification
The hardest case to reach from the ports is wrap-around of the 64-bit total. Counting up from zero would take far too long, so the stimulus preloads a value just below 2^64 through the accumulator address. It then enables accumulation with many transactions in flight, which also covers a load and an accumulation falling in the same cycle. Both ends of the in-flight count are reached as well: surplus deallocates are sent at zero and surplus allocates at the maximum. The reference model in the bench tracks every cycle, so any wrong step shows up in the next accumulator read.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned EN_BIT = 26;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_CNT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/lat_occ_track.sv
module lat_occ_track #(
  parameter int unsigned OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             dealloc_i,
  output logic [OCC_W-1:0] occ_o
);
  localparam logic [OCC_W-1:0] OCC_MAX = {OCC_W{1'b1}};

  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (alloc_i && !dealloc_i && occ_q != OCC_MAX) begin
      occ_q <= occ_q + 1'b1;
    end else if (dealloc_i && !alloc_i && occ_q != '0) begin
      occ_q <= occ_q - 1'b1;
    end
  end

  assign occ_o = occ_q;

  // R5: both pulses together keep the count
  a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && dealloc_i) |=> $stable(occ_q));
  // R6: no underflow below zero
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0 && dealloc_i && !alloc_i) |=> (occ_q == '0));
  // R6: no overflow past the maximum
  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_MAX && alloc_i && !dealloc_i) |=> (occ_q == OCC_MAX));
endmodule

// File: rtl/lat_accum.sv
module lat_accum #(
  parameter int unsigned OCC_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_i,
  input  logic [OCC_W-1:0]          occ_i,
  input  logic                      load_i,
  input  logic [lat_pkg::DATA_W-1:0] load_val_i,
  output logic [lat_pkg::DATA_W-1:0] acc_o
);
  import lat_pkg::*;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] weight;

  assign weight = {{(DATA_W-OCC_W){1'b0}}, occ_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load_i) begin
      acc_q <= load_val_i;
    end else if (en_i) begin
      acc_q <= acc_q + weight;
    end
  end

  assign acc_o = acc_q;

  // R7: frozen while disabled
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(acc_q));
  // R8: a load takes the written value
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == $past(load_val_i)));
  // R4: enabled cycle adds the in-flight count
  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i) |=> (acc_q - $past(acc_q) == $past(weight)));
endmodule

// File: rtl/lat_regs.sv
module lat_regs #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BASE_ADDR = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic [lat_pkg::DATA_W-1:0] wdata_i,
  input  logic [lat_pkg::DATA_W-1:0] acc_i,
  output logic                       en_o,
  output logic                       load_o,
  output logic [lat_pkg::DATA_W-1:0] load_val_o,
  output logic [lat_pkg::DATA_W-1:0] rdata_o
);
  import lat_pkg::*;

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(BASE_ADDR + 1);

  reg_sel_e sel;
  logic     en_q;

  always_comb begin
    if (addr_i == CTL_A)      sel = SEL_CTL;
    else if (addr_i == CNT_A) sel = SEL_CNT;
    else                      sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_i && sel == SEL_CTL) begin
      en_q <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTL: rdata_o[EN_BIT] = en_q;
      SEL_CNT: rdata_o = acc_i;
      default: rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign load_o     = wr_i && (sel == SEL_CNT);
  assign load_val_o = wdata_i;

  // R2: enable follows the written bit
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == SEL_CTL) |=> (en_q == $past(wdata_i[EN_BIT])));
  // R10: writes elsewhere leave the enable alone
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == SEL_NONE) |=> $stable(en_q));
endmodule

// File: rtl/lat_accum_top.sv
module lat_accum_top #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BASE_ADDR = 8,
  parameter int unsigned OCC_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              dealloc_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o
);
  import lat_pkg::*;

  logic [OCC_W-1:0]  occ;
  logic              en;
  logic              load;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] acc;

  lat_occ_track #(.OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .dealloc_i(dealloc_i),
    .occ_o(occ)
  );

  lat_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .acc_i(acc), .en_o(en), .load_o(load),
    .load_val_o(load_val), .rdata_o(reg_rdata_o)
  );

  lat_accum #(.OCC_W(OCC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en_i(en), .occ_i(occ), .load_i(load),
    .load_val_i(load_val), .acc_o(acc)
  );

  // R1: everything idle just after reset
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (acc == '0 && !en && occ == '0));
endmodule

// File: tb/test_lat_accum_top.sv
`timescale 1ns/1ps
module test_lat_accum_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_i = 1'b0;
  logic        dealloc_i = 1'b0;
  logic [3:0]  reg_addr_i = 4'd8;
  logic        reg_wr_i = 1'b0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;

  int total = 0;
  int bad = 0;

  int          m_occ = 0;
  logic        m_en = 1'b0;
  logic [63:0] m_acc = '0;

  localparam int OCC_MAX = 31;

  always #10 clk = ~clk;

  lat_accum_top i_lat_accum_top (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .dealloc_i(dealloc_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o)
  );

  function automatic logic [63:0] exp_rd(input logic [3:0] ad);
    if (ad == 4'd8) return 64'(m_en) << 26;
    if (ad == 4'd9) return m_acc;
    return 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic a, input logic d, input logic w,
                      input logic [3:0] ad, input logic [63:0] wd, input string tag);
    alloc_i = a; dealloc_i = d; reg_wr_i = w; reg_addr_i = ad; reg_wdata_i = wd;
    @(posedge clk);
    if (w && ad == 4'd9) m_acc = wd;
    else if (m_en) m_acc = m_acc + 64'(m_occ);
    if (w && ad == 4'd8) m_en = wd[26];
    if (a && !d && m_occ < OCC_MAX) m_occ++;
    else if (d && !a && m_occ > 0) m_occ--;
    @(negedge clk);
    check(tag, reg_rdata_o, exp_rd(ad));
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ctl", reg_rdata_o, 64'd0);
    step(0, 0, 0, 4'd9, 0, "R1 cnt");
    // R7 disabled: pulses tracked, total frozen
    repeat (3) step(1, 0, 0, 4'd9, 0, "R7 frozen at start");
    // R2 enable with all bits set; only bit 26 sticks
    step(0, 0, 1, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R2 ctl write");
    step(0, 0, 0, 4'd8, 0, "R2 ctl readback");
    // R4 accumulation with occupancy 3
    repeat (4) step(0, 0, 0, 4'd9, 0, "R4 accumulate");
    // R5 simultaneous pulses
    repeat (3) step(1, 1, 0, 4'd9, 0, "R5 both pulses");
    // R6 drain below zero
    repeat (6) step(0, 1, 0, 4'd9, 0, "R6 floor");
    step(0, 0, 0, 4'd9, 0, "R6 empty adds zero");
    // R6 fill past maximum
    repeat (36) step(1, 0, 0, 4'd9, 0, "R6 ceiling");
    step(0, 0, 0, 4'd9, 0, "R6 full weight");
    // R4/R5 mixed pattern
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3], 0, 4'd9, 0, "R4 mixed");
    end
    // R7 disable then pulse
    step(0, 0, 1, 4'd8, 64'd0, "R7 disable");
    repeat (5) step(1, 0, 0, 4'd9, 0, "R7 frozen");
    step(0, 0, 0, 4'd8, 0, "R2 ctl reads zero");
    // R8 load while disabled
    step(0, 0, 1, 4'd9, 64'h1234_5678_9ABC_DEF0, "R8 load");
    // R3 full-width readback
    step(0, 0, 0, 4'd9, 0, "R3 count width");
    // R9 wrap: preload near top, enable
    step(0, 0, 1, 4'd9, 64'hFFFF_FFFF_FFFF_FFF0, "R9 preload");
    step(0, 0, 1, 4'd8, 64'h0000_0000_0400_0000, "R2 enable bit only");
    repeat (3) step(0, 0, 0, 4'd9, 0, "R9 wrap");
    // R8 load while enabled overrides accumulation
    step(0, 0, 1, 4'd9, 64'd100, "R8 load beats add");
    step(0, 0, 0, 4'd9, 0, "R8 after load");
    // R10 unmapped addresses
    step(0, 0, 1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R10 write unmapped");
    step(0, 0, 0, 4'd15, 0, "R10 read unmapped");
    step(0, 0, 1, 4'd0, 64'd0, "R10 write unmapped 2");
    step(0, 0, 0, 4'd8, 0, "R10 ctl unchanged");
    step(0, 0, 0, 4'd9, 0, "R10 count unchanged");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule